// File: doc/BRIEF.md
# DDR Write Burst Truncation Sequencer

This block sits on the controller side of a four-bank DDR SDRAM interface. It accepts one request at a time on a valid/ready handshake. A request is either a write, which carries a bank, a column, eight data beats and a count of how many leading beats are meaningful, or a precharge of one bank. The block turns each request into a one-cycle command on the command bus. For a write, it then streams the burst of eight beats as four clock cycles with a rising-edge beat and a falling-edge beat in each.

A write burst can be cut short in two ways. A later write to any column takes over the data bus as soon as the last meaningful beat of the earlier burst has gone out. A precharge to the same bank can also arrive while the burst slot is still running. Beats beyond the meaningful count are always driven with the data mask set. The strobe keeps running for the whole four-cycle slot, so a precharge does not stop it.

A precharge is held off with ready low until write recovery has elapsed. The recovery interval is counted in command-clock cycles from the clock of the last meaningful beat, plus the worst-case strobe delay rounded up to whole clocks, plus the recovery time. A busy bank never holds back a request to another bank.

Top module: `ddrwi_seq`

The command issuer is a three-state machine:
- ISS_NOP: no command on the bus.
- ISS_WRITE: a write command on the bus.
- ISS_PRE: a precharge command on the bus.

In every state, an accepted write moves the machine to ISS_WRITE and an accepted precharge moves it to ISS_PRE. With no acceptance it goes to ISS_NOP.

The data slot is a two-state machine:
- SL_IDLE moves to SL_STREAM when a launched burst is pending.
- SL_STREAM advances one beat pair per cycle.
- SL_STREAM returns to SL_IDLE after pair 3.
- SL_STREAM reloads at pair 0 when a newer burst is pending. This is the interruption path.

## Requirements
- R1: While reset is asserted, and on the first cycle after it, cmd_code is NOP, dqs_en is 0, dm_rise and dm_fall are 1, and req_ready is 1.
- R2: A request accepted at the end of cycle c puts its command on the bus in cycle c+1. The codes are NOP = 2'b00, WRITE = 2'b01 and PRECHARGE = 2'b10. cmd_bank is the request bank. cmd_col is the request column for a write and 0 for a precharge. In every cycle that follows no acceptance, cmd_code is NOP and cmd_bank and cmd_col are 0.
- R3: For a write whose command is in cycle W, dqs_en is 1 in cycles W+1 to W+4, unless a newer burst replaces it. In cycle W+1+p, dq_rise carries beat 2p and dq_fall carries beat 2p+1. Beat b occupies req_data bits [b*DQ_W +: DQ_W].
- R4: req_nbeats holds the number of meaningful beats minus one. Beat b is driven with its mask bit at 1 when b > req_nbeats and at 0 otherwise, so req_nbeats = 7 sends all eight beats unmasked.
- R5: A write is accepted only when its command cycle is no earlier than L, the cycle carrying the last meaningful beat of the previous write (L = W+1+req_nbeats/2). From the cycle after the new command, the new burst replaces the rest of the old slot.
- R6: A precharge to a bank is accepted only when its command cycle is at least L + DQSS_XTRA + TWR, where L belongs to the latest write to that bank. Until then req_ready stays 0.
- R7: Recovery pending on one bank does not lower req_ready for a precharge to a different bank.
- R8: A precharge issued while a burst slot is running leaves dqs_en at 1 for the rest of the slot, with those beats masked.
- R9: Outside any burst slot, dqs_en is 0, both mask bits are 1 and both data buses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_is_pre | input | 1 | 1 for precharge, 0 for write |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Write column |
| req_nbeats | input | 3 | Meaningful beats minus one |
| req_data | input | 8*DQ_W | Eight write beats, beat 0 lowest |
| cmd_code | output | 2 | Command on the bus |
| cmd_bank | output | BANK_W | Command bank |
| cmd_col | output | COL_W | Command column |
| dqs_en | output | 1 | Strobe toggling enable |
| dq_rise | output | DQ_W | Rising-edge beat |
| dq_fall | output | DQ_W | Falling-edge beat |
| dm_rise | output | 1 | Mask for the rising-edge beat |
| dm_fall | output | 1 | Mask for the falling-edge beat |

## Verification
The bench builds the block with four banks, a 16-bit data path, TWR = 1 and DQSS_XTRA = 1. With this short recovery, a precharge following a one-beat write lands two cycles before the end of the burst slot, which brings the masked-strobe-after-precharge case within reach. Full-burst writes push the same-bank bound past the end of the slot. Write counts of one and two beats allow back-to-back writes that take over an earlier slot after its first pair. The reference model predicts command, strobe, masks and data for every cycle, and req_ready for every cycle a request waits.

// File: rtl/ddrwi_pkg.sv
package ddrwi_pkg;

    localparam int BEATS = 8;
    localparam int PAIRS = BEATS / 2;
    localparam int NBW   = $clog2(BEATS);
    localparam int PW    = $clog2(PAIRS);

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_WRITE = 2'b01,
        CMD_PRE   = 2'b10
    } cmd_e;

    typedef enum logic [1:0] {
        ISS_NOP,
        ISS_WRITE,
        ISS_PRE
    } iss_state_e;

    typedef enum logic {
        SL_IDLE,
        SL_STREAM
    } slot_state_e;

endpackage

// File: rtl/ddrwi_recov_timer.sv
module ddrwi_recov_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          ok
);

    logic [CW-1:0] cnt;

    // Down-counter: the decision for the next cycle is legal once at most one cycle remains
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign ok = (cnt <= CW'(1));

    AST_OK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && !load) |=> ok);  // R6

    AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (load_val > CW'(2))) |=> !ok);  // R6

endmodule

// File: rtl/ddrwi_data_slot.sv
module ddrwi_data_slot
    import ddrwi_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  launch,
    input  logic [BEATS*DQ_W-1:0] launch_data,
    input  logic [NBW-1:0]        launch_nb,
    output logic                  dqs_en,
    output logic [DQ_W-1:0]       dq_rise,
    output logic [DQ_W-1:0]       dq_fall,
    output logic                  dm_rise,
    output logic                  dm_fall
);

    slot_state_e           st;
    logic [PW-1:0]         pair;
    logic [BEATS*DQ_W-1:0] cur_data;
    logic [NBW-1:0]        cur_nb;
    logic                  pend_vld;
    logic [BEATS*DQ_W-1:0] pend_data;
    logic [NBW-1:0]        pend_nb;
    logic [NBW-1:0]        rise_idx;
    logic [NBW-1:0]        fall_idx;

    // State register: a pending burst (launched in the command cycle) always wins the slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= SL_IDLE;
            pair      <= '0;
            cur_data  <= '0;
            cur_nb    <= '0;
            pend_vld  <= 1'b0;
            pend_data <= '0;
            pend_nb   <= '0;
        end else begin
            pend_vld <= launch;
            if (launch) begin
                pend_data <= launch_data;
                pend_nb   <= launch_nb;
            end
            unique case (st)
                SL_IDLE: begin
                    if (pend_vld) begin
                        st       <= SL_STREAM;
                        pair     <= '0;
                        cur_data <= pend_data;
                        cur_nb   <= pend_nb;
                    end
                end
                SL_STREAM: begin
                    if (pend_vld) begin
                        pair     <= '0;
                        cur_data <= pend_data;
                        cur_nb   <= pend_nb;
                    end else if (pair == PW'(PAIRS - 1)) begin
                        st <= SL_IDLE;
                    end else begin
                        pair <= pair + PW'(1);
                    end
                end
            endcase
        end
    end

    assign rise_idx = {pair, 1'b0};
    assign fall_idx = {pair, 1'b1};

    // Outputs
    always_comb begin
        dqs_en  = 1'b0;
        dq_rise = '0;
        dq_fall = '0;
        dm_rise = 1'b1;
        dm_fall = 1'b1;
        unique case (st)
            SL_IDLE: begin
            end
            SL_STREAM: begin
                dqs_en  = 1'b1;
                dq_rise = cur_data[int'(rise_idx)*DQ_W +: DQ_W];
                dq_fall = cur_data[int'(fall_idx)*DQ_W +: DQ_W];
                dm_rise = (rise_idx > cur_nb);
                dm_fall = (fall_idx > cur_nb);
            end
        endcase
    end

    AST_STROBE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dqs_en) |=> dqs_en);  // R3

    AST_IDLE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !dqs_en |-> (dm_rise && dm_fall && dq_rise == '0 && dq_fall == '0));  // R9

endmodule

// File: rtl/ddrwi_seq.sv
module ddrwi_seq
    import ddrwi_pkg::*;
#(
    parameter int NBANK     = 4,
    parameter int COL_W     = 10,
    parameter int DQ_W      = 16,
    parameter int TWR       = 3,
    parameter int DQSS_XTRA = 1,
    localparam int BANK_W   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_is_pre,
    input  logic [BANK_W-1:0]     req_bank,
    input  logic [COL_W-1:0]      req_col,
    input  logic [2:0]            req_nbeats,
    input  logic [BEATS*DQ_W-1:0] req_data,
    output logic [1:0]            cmd_code,
    output logic [BANK_W-1:0]     cmd_bank,
    output logic [COL_W-1:0]      cmd_col,
    output logic                  dqs_en,
    output logic [DQ_W-1:0]       dq_rise,
    output logic [DQ_W-1:0]       dq_fall,
    output logic                  dm_rise,
    output logic                  dm_fall
);

    localparam int CW = $clog2(PAIRS + DQSS_XTRA + TWR + 1);

    logic              accept;
    logic              wr_accept;
    logic [CW-1:0]     bus_ld_val;
    logic [CW-1:0]     bank_ld_val;
    logic              bus_ok;
    logic [NBANK-1:0]  bank_ok;
    iss_state_e        st;
    iss_state_e        st_nxt;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_q;

    assign accept    = req_valid && req_ready;
    assign wr_accept = accept && !req_is_pre;

    // Cycles from the write command to its last meaningful beat, then to the precharge bound
    assign bus_ld_val  = CW'(1 + int'(req_nbeats >> 1));
    assign bank_ld_val = CW'(1 + int'(req_nbeats >> 1) + DQSS_XTRA + TWR);

    ddrwi_recov_timer #(.CW(CW)) u_bus_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_accept),
        .load_val (bus_ld_val),
        .ok       (bus_ok)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        ddrwi_recov_timer #(.CW(CW)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (wr_accept && (req_bank == BANK_W'(b))),
            .load_val (bank_ld_val),
            .ok       (bank_ok[b])
        );
    end

    assign req_ready = req_is_pre ? bank_ok[req_bank] : bus_ok;

    // Next state of the command issuer
    always_comb begin
        if (!accept) begin
            st_nxt = ISS_NOP;
        end else if (req_is_pre) begin
            st_nxt = ISS_PRE;
        end else begin
            st_nxt = ISS_WRITE;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ISS_NOP;
            bank_q <= '0;
            col_q  <= '0;
        end else begin
            st     <= st_nxt;
            bank_q <= accept ? req_bank : '0;
            col_q  <= wr_accept ? req_col : '0;
        end
    end

    // Outputs
    always_comb begin
        cmd_bank = bank_q;
        cmd_col  = col_q;
        unique case (st)
            ISS_NOP:   cmd_code = CMD_NOP;
            ISS_WRITE: cmd_code = CMD_WRITE;
            ISS_PRE:   cmd_code = CMD_PRE;
            default:   cmd_code = CMD_NOP;
        endcase
    end

    ddrwi_data_slot #(.DQ_W(DQ_W)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (wr_accept),
        .launch_data (req_data),
        .launch_nb   (req_nbeats),
        .dqs_en      (dqs_en),
        .dq_rise     (dq_rise),
        .dq_fall     (dq_fall),
        .dm_rise     (dm_rise),
        .dm_fall     (dm_fall)
    );

    AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (cmd_code != CMD_NOP));  // R2

    AST_QUIET_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> (cmd_code == CMD_NOP && cmd_bank == '0 && cmd_col == '0));  // R2

    AST_WRITE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_WRITE) |=> dqs_en);  // R3

endmodule

// File: tb/ddrwi_seq_bench.sv
module ddrwi_seq_bench;

    localparam int NBANK = 4;
    localparam int COL_W = 10;
    localparam int DQ_W  = 16;
    localparam int TWR   = 1;
    localparam int XTRA  = 1;
    localparam int BW    = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_is_pre = 1'b0;
    logic [BW-1:0]    req_bank = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [2:0]       req_nbeats = '0;
    logic [8*DQ_W-1:0] req_data = '0;
    logic [1:0]       cmd_code;
    logic [BW-1:0]    cmd_bank;
    logic [COL_W-1:0] cmd_col;
    logic             dqs_en;
    logic [DQ_W-1:0]  dq_rise, dq_fall;
    logic             dm_rise, dm_fall;

    always #4 clk = ~clk;

    ddrwi_seq #(.NBANK(NBANK), .COL_W(COL_W), .DQ_W(DQ_W), .TWR(TWR), .DQSS_XTRA(XTRA)) u_ddrwi_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_pre(req_is_pre), .req_bank(req_bank), .req_col(req_col),
        .req_nbeats(req_nbeats), .req_data(req_data), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .cmd_col(cmd_col), .dqs_en(dqs_en),
        .dq_rise(dq_rise), .dq_fall(dq_fall), .dm_rise(dm_rise), .dm_fall(dm_fall)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int bus_ok = 0;
    int pre_ok [NBANK];
    int e_cmd [int];
    int e_bank [int];
    int e_col [int];
    bit e_dqs [int];
    int e_dqr [int];
    int e_dqf [int];
    bit e_dmr [int];
    bit e_dmf [int];

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
        end
    endtask

    function automatic bit mdl_ready(bit pre, int bank, int c);
        return pre ? (c + 1 >= pre_ok[bank]) : (c + 1 >= bus_ok);
    endfunction

    function automatic logic [8*DQ_W-1:0] mk(int s);
        logic [8*DQ_W-1:0] v;
        for (int b = 0; b < 8; b++) v[b*DQ_W +: DQ_W] = DQ_W'(s * 256 + b * 17 + 'h1000);
        return v;
    endfunction

    // Reference model: records what each future cycle must show
    always @(posedge clk) begin
        if (rst_n) begin
            if (req_valid && mdl_ready(req_is_pre, int'(req_bank), cyc)) begin
                int w;
                int last;
                w = cyc + 1;
                e_cmd[w]  = req_is_pre ? 2 : 1;
                e_bank[w] = int'(req_bank);
                e_col[w]  = req_is_pre ? 0 : int'(req_col);
                if (!req_is_pre) begin
                    last = w + 1 + int'(req_nbeats) / 2;
                    bus_ok = last;
                    pre_ok[req_bank] = last + XTRA + TWR;
                    for (int p = 0; p < 4; p++) begin
                        e_dqs[w+1+p] = 1'b1;
                        e_dqr[w+1+p] = int'(req_data[(2*p)*DQ_W +: DQ_W]);
                        e_dqf[w+1+p] = int'(req_data[(2*p+1)*DQ_W +: DQ_W]);
                        e_dmr[w+1+p] = (2*p > int'(req_nbeats));
                        e_dmf[w+1+p] = (2*p+1 > int'(req_nbeats));
                    end
                end
            end
            cyc++;
        end
    end

    // Per-cycle comparison
    always @(negedge clk) begin
        string tc, td, tm;
        int xc, xb, xl, xr, xf;
        bit xs, xmr, xmf;
        tc = rst_n ? "R2" : "R1";
        xc = e_cmd.exists(cyc) ? e_cmd[cyc] : 0;
        xb = e_bank.exists(cyc) ? e_bank[cyc] : 0;
        xl = e_col.exists(cyc) ? e_col[cyc] : 0;
        if (e_dqs.exists(cyc)) begin
            xs = 1'b1; xr = e_dqr[cyc]; xf = e_dqf[cyc]; xmr = e_dmr[cyc]; xmf = e_dmf[cyc];
            td = "R3"; tm = "R4";
        end else begin
            xs = 1'b0; xr = 0; xf = 0; xmr = 1'b1; xmf = 1'b1;
            td = rst_n ? "R9" : "R1"; tm = td;
        end
        chk(int'(cmd_code) == xc, tc, "cmd_code", int'(cmd_code), xc);
        chk(int'(cmd_bank) == xb && int'(cmd_col) == xl, tc, "cmd_bank/col",
            int'({cmd_bank, cmd_col}), int'({BW'(xb), COL_W'(xl)}));
        chk(dqs_en == xs, td, "dqs_en", int'(dqs_en), int'(xs));
        chk(int'(dq_rise) == xr && int'(dq_fall) == xf, td, "dq pair",
            int'({dq_rise, dq_fall}), int'({DQ_W'(xr), DQ_W'(xf)}));
        chk(dm_rise == xmr && dm_fall == xmf, tm, "dm pair",
            int'({dm_rise, dm_fall}), int'({xmr, xmf}));
    end

    task automatic send(bit pre, int bank, int col, int nb, logic [8*DQ_W-1:0] d, string tag);
        bit r;
        @(negedge clk);
        req_valid = 1'b1; req_is_pre = pre; req_bank = BW'(bank);
        req_col = COL_W'(col); req_nbeats = 3'(nb); req_data = d;
        forever begin
            #1;
            r = mdl_ready(pre, bank, cyc);
            chk(req_ready == r, tag, "req_ready", int'(req_ready), int'(r));
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        #1 req_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int b = 0; b < NBANK; b++) pre_ok[b] = 0;
        idle(3);
        #1 chk(req_ready == 1'b1, "R1", "req_ready in reset", int'(req_ready), 1);
        @(negedge clk) rst_n = 1'b1;
        // R4: full burst, every beat unmasked
        send(1'b0, 0, 'h010, 7, mk(1), "R5");
        idle(6);
        // R6: same-bank precharge waits for recovery after a full burst
        send(1'b0, 0, 'h020, 7, mk(2), "R5");
        send(1'b1, 0, 0, 0, '0, "R6");
        idle(4);
        // R7: other bank precharge not held by bank 2 recovery
        send(1'b0, 2, 'h033, 7, mk(3), "R5");
        send(1'b1, 1, 0, 0, '0, "R7");
        idle(6);
        // R8: precharge lands inside the slot of a one-beat write
        send(1'b0, 1, 'h044, 0, mk(4), "R5");
        send(1'b1, 1, 0, 0, '0, "R6");
        @(negedge clk);
        chk(dqs_en && dm_rise && dm_fall && cmd_code == 2'b10, "R8", "strobe at precharge",
            int'({dqs_en, dm_rise, dm_fall}), 7);
        idle(6);
        // R5: new column write interrupts a three-beat burst
        send(1'b0, 2, 'h050, 2, mk(5), "R5");
        send(1'b0, 3, 'h060, 7, mk(6), "R5");
        idle(6);
        // R5: back-to-back short writes replace slots after one pair
        send(1'b0, 0, 'h070, 0, mk(7), "R5");
        send(1'b0, 1, 'h071, 1, mk(8), "R5");
        send(1'b0, 2, 'h072, 3, mk(9), "R5");
        idle(6);
        // R4: odd partial counts, then R6 precharge
        send(1'b0, 3, 'h080, 4, mk(10), "R4");
        send(1'b1, 3, 0, 0, '0, "R6");
        send(1'b0, 0, 'h090, 5, mk(11), "R4");
        idle(8);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 5000);
        n_bad++;
        $display("FAIL R2 watchdog: actual hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule